// File: doc/BRIEF.md
# Reversible-Gate Crosswise Multiplier

This block is a purely combinational unsigned multiplier. It uses the vertical-and-crosswise partial-product method, and every piece of logic in it comes from instantiated reversible primitives. There are three primitives: the Peres gate, the Feynman gate and the HNG gate. Each primitive is a bijection between its inputs and outputs. Constant inputs are tied to zero, and unused outputs stay inside the cell as garbage.

The leaf is a 2x2 product cell, built from five Peres gates and one Feynman gate. Four leaf cells and a partial-product combiner form a 4x4 multiplier. Four 4x4 multipliers and a second combiner, one level up, form the 8x8 top. Each combiner is built from reversible ripple-carry adders. In each ripple adder, a Peres half adder takes the bit with no carry in, and HNG full adders take the remaining bits. There is no clock and no state: the 16-bit product follows the two 8-bit operands through gate delay alone.

Top module: `rv_vedic_mul8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `y_o` equals `a_i * b_i` as a 16-bit value. This includes 0 x 0 = 0 and 255 x 255 = 65025 (0xFE01).
- R2: The 4x4 stage `rv_mul4` returns the exact 8-bit product for all 256 operand pairs.
- R3: The 2x2 leaf `rv_mul_core2` returns the exact 4-bit product for all 16 operand pairs.
- R4: The Peres primitive maps (A,B,C) to P=A, Q=A^B, R=(A&B)^C. Packed as {P,Q,R} against the input {A,B,C}, its 8 output codes are all distinct.
- R5: The Feynman primitive maps (A,B) to P=A, Q=A^B. Packed as {P,Q} against {A,B}, its 4 output codes are all distinct.
- R6: The HNG primitive maps (A,B,C,D) to P=A, Q=B, R=A^B^C, S=((A^B)&C)^(A&B)^D. Packed as {P,Q,R,S} against {A,B,C,D}, its 16 output codes are all distinct.
- R7: The reversible ripple adder of width W returns the exact (W+1)-bit sum of its two operands. The 4-bit instance is checked for all 256 pairs.
- R8: Product bits [3:0] depend only on the low operand nibbles. They equal the low four bits of `a_i[3:0] * b_i[3:0]`.
- R9: No combiner adder carries out of its top bit for any legal operands, so the upper product bits are never truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| y_o | output | 16 | Full-width unsigned product |

## Verification
Every result is due in the same cycle as its stimulus, because there are no registers anywhere in the path. The bench changes operands one time unit after a rising edge and compares them with its integer model on the following falling edge. The combinational outputs have therefore settled by the time they are sampled, and no result depends on the order of processes at the edge. Each primitive is enumerated over its full input space, and its output codes are collected to confirm it is a bijection. The adder, the 2x2 leaf, the 4x4 stage and the 8x8 top are each driven through every operand pair.

// File: rtl/rv_mul_pkg.sv
package rv_mul_pkg;
  localparam int unsigned LEAF_W = 2;
  localparam int unsigned TOP_W  = 8;

  // width of the product bits above the pass-through low half-operand field
  function automatic int unsigned upper_w(input int unsigned prod_w);
    return 2 * prod_w - prod_w / 2;
  endfunction
endpackage

// File: rtl/rv_gates.sv
module rv_peres (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = (a_i & b_i) ^ c_i;
endmodule

module rv_feynman (
  input  logic a_i,
  input  logic b_i,
  output logic p_o,
  output logic q_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
endmodule

module rv_hng (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic p_o,
  output logic q_o,
  output logic r_o,
  output logic s_o
);
  logic x_ab;
  assign x_ab = a_i ^ b_i;
  assign p_o  = a_i;
  assign q_o  = b_i;
  assign r_o  = x_ab ^ c_i;
  assign s_o  = (x_ab & c_i) ^ (a_i & b_i) ^ d_i;
endmodule

// File: rtl/rv_ripple_add.sv
module rv_ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   s_o
);
  logic [W-1:0] cy;
  logic [W-1:0] unused_p;
  logic [W-1:0] unused_q;

  // bit 0 has no carry in: Peres as half adder
  rv_peres u_ha (
    .a_i(a_i[0]), .b_i(b_i[0]), .c_i(1'b0),
    .p_o(unused_p[0]), .q_o(s_o[0]), .r_o(cy[0])
  );

  for (genvar i = 1; i < W; i++) begin : g_fa
    rv_hng u_fa (
      .a_i(a_i[i]), .b_i(b_i[i]), .c_i(cy[i-1]), .d_i(1'b0),
      .p_o(unused_p[i]), .q_o(unused_q[i]), .r_o(s_o[i]), .s_o(cy[i])
    );
  end

  assign unused_q[0] = 1'b0;
  assign s_o[W]      = cy[W-1];

  always_comb begin
    if (!$isunknown({a_i, b_i}))
      a_r7_exact_sum: assert (s_o == (W+1)'(a_i) + (W+1)'(b_i));
  end
endmodule

// File: rtl/rv_mul_core2.sv
module rv_mul_core2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] y_o
);
  logic t_hl, t_lh, t_hh;
  logic [11:0] unused_g;

  rv_peres u_hl (.a_i(a_i[1]), .b_i(b_i[0]), .c_i(1'b0),
                 .p_o(unused_g[0]), .q_o(unused_g[1]), .r_o(t_hl));
  rv_peres u_lh (.a_i(a_i[0]), .b_i(b_i[1]), .c_i(1'b0),
                 .p_o(unused_g[2]), .q_o(unused_g[3]), .r_o(t_lh));
  rv_peres u_ll (.a_i(a_i[0]), .b_i(b_i[0]), .c_i(1'b0),
                 .p_o(unused_g[4]), .q_o(unused_g[5]), .r_o(y_o[0]));
  rv_peres u_hh (.a_i(a_i[1]), .b_i(b_i[1]), .c_i(1'b0),
                 .p_o(unused_g[6]), .q_o(unused_g[7]), .r_o(t_hh));
  // cross terms: sum bit 1, their AND is the top bit (all four inputs set)
  rv_peres u_x  (.a_i(t_hl), .b_i(t_lh), .c_i(1'b0),
                 .p_o(unused_g[8]), .q_o(y_o[1]), .r_o(y_o[3]));
  rv_feynman u_f (.a_i(y_o[3]), .b_i(t_hh), .p_o(unused_g[9]), .q_o(y_o[2]));

  assign unused_g[11:10] = 2'b00;

  always_comb begin
    if (!$isunknown({a_i, b_i}))
      a_r3_leaf_product: assert (y_o == {2'b00, a_i} * {2'b00, b_i});
  end
endmodule

// File: rtl/rv_mul_combine.sv
// Merges four half-width products q[k] = a_half[k>>1] * b_half[k&1]
module rv_mul_combine #(
  parameter int unsigned N = 4
) (
  input  logic [3:0][N-1:0] q_i,
  output logic [2*N-1:0]    y_o
);
  localparam int unsigned H  = N / 2;
  localparam int unsigned UW = rv_mul_pkg::upper_w(N);

  logic [N:0]  s_cross;
  logic [N:0]  s_high;
  logic [UW-1:0] v_high;
  logic [UW:0] s_fin;

  // low cross term plus the upper half of the lowest product
  rv_ripple_add #(.W(N)) u_add_lo (
    .a_i(q_i[1]), .b_i({{H{1'b0}}, q_i[0][N-1:H]}), .s_o(s_cross)
  );
  // highest product plus upper half of the other cross term
  rv_ripple_add #(.W(N)) u_add_hi (
    .a_i(q_i[3]), .b_i({{H{1'b0}}, q_i[2][N-1:H]}), .s_o(s_high)
  );

  assign v_high = {s_high[N-1:0], q_i[2][H-1:0]};

  rv_ripple_add #(.W(UW)) u_add_fin (
    .a_i({{(UW-N-1){1'b0}}, s_cross}), .b_i(v_high), .s_o(s_fin)
  );

  assign y_o = {s_fin[UW-1:0], q_i[0][H-1:0]};

  always_comb begin
    if (!$isunknown(q_i)) begin
      a_r9_no_overflow: assert (s_fin[UW] == 1'b0);
      a_r9_high_fits:   assert (s_high[N] == 1'b0);
    end
  end
endmodule

// File: rtl/rv_mul4.sv
module rv_mul4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [7:0] y_o
);
  localparam int unsigned HW = rv_mul_pkg::LEAF_W;
  localparam int unsigned PW = 2 * HW;

  logic [3:0][PW-1:0] q;

  for (genvar k = 0; k < 4; k++) begin : g_leaf
    rv_mul_core2 u_leaf (
      .a_i(a_i[(k/2)*HW +: HW]),
      .b_i(b_i[(k%2)*HW +: HW]),
      .y_o(q[k])
    );
  end

  rv_mul_combine #(.N(PW)) u_comb (.q_i(q), .y_o(y_o));

  always_comb begin
    if (!$isunknown({a_i, b_i}))
      a_r2_mul4_product: assert (y_o == {4'b0, a_i} * {4'b0, b_i});
  end
endmodule

// File: rtl/rv_vedic_mul8.sv
module rv_vedic_mul8 (
  input  logic [7:0]  a_i,
  input  logic [7:0]  b_i,
  output logic [15:0] y_o
);
  localparam int unsigned OW = rv_mul_pkg::TOP_W;
  localparam int unsigned HW = OW / 2;
  localparam int unsigned PW = 2 * HW;

  logic [3:0][PW-1:0] p;

  for (genvar k = 0; k < 4; k++) begin : g_sub
    rv_mul4 u_sub (
      .a_i(a_i[(k/2)*HW +: HW]),
      .b_i(b_i[(k%2)*HW +: HW]),
      .y_o(p[k])
    );
  end

  rv_mul_combine #(.N(PW)) u_comb (.q_i(p), .y_o(y_o));

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r1_full_product: assert (y_o == {8'b0, a_i} * {8'b0, b_i});
      a_r8_low_nibble:   assert (y_o[3:0] == 4'(a_i[3:0] * b_i[3:0]));
    end
  end
endmodule

// File: tb/tb_rv_vedic_mul8.sv
module tb_rv_vedic_mul8;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8;
  logic [15:0] y8;
  logic [3:0]  a4, b4;
  logic [7:0]  y4;
  logic [1:0]  a2, b2;
  logic [3:0]  y2;
  logic [3:0]  ra, rb;
  logic [4:0]  rs;
  logic pa, pb, pc, pp, pq, pr;
  logic fa, fb, fp, fq;
  logic ha, hb, hc, hd, hp, hq, hr, hs;

  rv_vedic_mul8 dut (.a_i(a8), .b_i(b8), .y_o(y8));
  rv_mul4 u_m4 (.a_i(a4), .b_i(b4), .y_o(y4));
  rv_mul_core2 u_m2 (.a_i(a2), .b_i(b2), .y_o(y2));
  rv_ripple_add #(.W(4)) u_add (.a_i(ra), .b_i(rb), .s_o(rs));
  rv_peres u_pg (.a_i(pa), .b_i(pb), .c_i(pc), .p_o(pp), .q_o(pq), .r_o(pr));
  rv_feynman u_fg (.a_i(fa), .b_i(fb), .p_o(fp), .q_o(fq));
  rv_hng u_hg (.a_i(ha), .b_i(hb), .c_i(hc), .d_i(hd),
               .p_o(hp), .q_o(hq), .r_o(hr), .s_o(hs));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step_in();
    @(posedge clk);
    #1;
  endtask

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0; ra = '0; rb = '0;
    {pa, pb, pc} = '0; {fa, fb} = '0; {ha, hb, hc, hd} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 idle zero", 32'(y8), 32'd0);
    rst_ni = 1'b1;

    // R4: Peres mapping and bijection
    begin
      logic [7:0] seen = '0;
      for (int i = 0; i < 8; i++) begin
        step_in();
        {pa, pb, pc} = 3'(i);
        @(negedge clk);
        check("R4 peres map", 32'({pp, pq, pr}),
              32'({pa, pa ^ pb, (pa & pb) ^ pc}));
        seen[{pp, pq, pr}] = 1'b1;
      end
      check("R4 peres bijective", 32'(seen), 32'hFF);
    end

    // R5: Feynman mapping and bijection
    begin
      logic [3:0] seen = '0;
      for (int i = 0; i < 4; i++) begin
        step_in();
        {fa, fb} = 2'(i);
        @(negedge clk);
        check("R5 feynman map", 32'({fp, fq}), 32'({fa, fa ^ fb}));
        seen[{fp, fq}] = 1'b1;
      end
      check("R5 feynman bijective", 32'(seen), 32'hF);
    end

    // R6: HNG mapping and bijection
    begin
      logic [15:0] seen = '0;
      for (int i = 0; i < 16; i++) begin
        step_in();
        {ha, hb, hc, hd} = 4'(i);
        @(negedge clk);
        check("R6 hng map", 32'({hp, hq, hr, hs}),
              32'({ha, hb, ha ^ hb ^ hc, ((ha ^ hb) & hc) ^ (ha & hb) ^ hd}));
        seen[{hp, hq, hr, hs}] = 1'b1;
      end
      check("R6 hng bijective", 32'(seen), 32'hFFFF);
    end

    // R7: 4-bit reversible ripple adder, exhaustive
    for (int i = 0; i < 256; i++) begin
      step_in();
      ra = 4'(i >> 4); rb = 4'(i);
      @(negedge clk);
      check("R7 ripple sum", 32'(rs), (i >> 4) + (i & 15));
    end

    // R3: 2x2 leaf, exhaustive
    for (int i = 0; i < 16; i++) begin
      step_in();
      a2 = 2'(i >> 2); b2 = 2'(i);
      @(negedge clk);
      check("R3 leaf product", 32'(y2), (i >> 2) * (i & 3));
    end

    // R2: 4x4 stage, exhaustive
    for (int i = 0; i < 256; i++) begin
      step_in();
      a4 = 4'(i >> 4); b4 = 4'(i);
      @(negedge clk);
      check("R2 mul4 product", 32'(y4), (i >> 4) * (i & 15));
    end

    // R9: corner operands that stress the top carries
    step_in();
    a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk);
    check("R9 max operands no truncation", 32'(y8), 32'hFE01);
    step_in();
    a8 = 8'h80; b8 = 8'hFF;
    @(negedge clk);
    check("R9 high bit times max", 32'(y8), 32'h7F80);

    // R1 and R8: 8x8 top, exhaustive
    for (int i = 0; i < 65536; i++) begin
      step_in();
      a8 = 8'(i >> 8); b8 = 8'(i);
      @(negedge clk);
      check("R1 mul8 product", 32'(y8), (i >> 8) * (i & 255));
      if ((i & 63) == 0)
        check("R8 low nibble", 32'(y8[3:0]), (((i >> 8) & 15) * (i & 15)) & 15);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule